// File: doc/BRIEF.md
# Relocatable Peripheral Window Address Decoder

This block steers every bus request to exactly one of four targets: a movable 1 GB window that holds the on-chip peripherals, a 64 KB internal RAM region, a fixed cache region, or external SDRAM. When several regions claim the same address, a fixed ranking decides. The peripheral window ranks highest, then RAM, then cache. SDRAM takes any address that nothing else claims.

The window's own base register lives inside the window. The RAM base register sits next to it. Both are read and written through ordinary requests that land in the window. After reset the window already decodes at 0x4000_0000, so software can find these registers. Software may move the window, disable it, or place the RAM anywhere on a 64 KB boundary.

Offsets inside the window that belong to no module are reserved. An access to one of them does not hang the bus. It produces an error flag for the cycle of the request, reads back zero and changes no state. Selects, error and read data are combinational on the current request. A register write takes effect at the clock edge that ends the request cycle.

Top module: `periph_window_decoder`

## Requirements
- R1: After reset the window base register reads 0x4000_0001 (base 0x4000_0000, enable bit 0 set) and the RAM base register reads 0x0000_0000; the window decodes at once.
- R2: A request hits the window when the window enable bit is 1 and address bits [31:30] equal base bits [31:30].
- R3: A write to window offset 0x00 stores data bits [31:30] and bit 0 only, and the other bits read as zero. The new value applies from the next cycle, and the write cycle itself decodes with the old base.
- R4: With the window enable bit cleared, no address selects the window.
- R5: A write to window offset 0x08 stores RAM base bits [31:16] and enable bit 0, and the other bits read as zero. When enabled, addresses whose bits [31:16] equal the base select RAM (64 KB).
- R6: Addresses with bits [31:24] equal to 0x00 form the cache region (0x0000_0000 to 0x00FF_FFFF).
- R7: Overlaps resolve as window over RAM over cache over SDRAM, and SDRAM takes every unclaimed address.
- R8: tgt_sel is one-hot when req_valid is 1 (bit 0 window, bit 1 RAM, bit 2 cache, bit 3 SDRAM) and all zero when req_valid is 0.
- R9: A window access to a reserved offset sets err in that cycle and reads back zero, and a write to it changes no register. Reserved offsets are 0x04 and 0x0C to 0x3F of the register block, and everything from 0x20_0000 upward.
- R10: Window offsets from 0x40 to 0x1F_FFFF are module space: they select the window with err low and read data zero.
- R11: A read of offset 0x00 or 0x08 returns that register's value on rd_data in the request cycle, and rd_data is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| tgt_sel | output | 4 | One-hot target: [0] window, [1] RAM, [2] cache, [3] SDRAM |
| rd_data | output | 32 | Read data from the decoder's own registers |
| err | output | 1 | Reserved-offset access in this cycle |

## Verification
Two functions can fall in one cycle: a write that relocates or disables the window, and the decode of that same request, which must still use the old base. The bench writes a new base through the old window and samples tgt_sel in that cycle, where it expects the window. It then probes the old and the new location on the following cycles. The same overlap is also provoked by stacking the window, RAM and cache on address zero and removing them one at a time, so that the selected target can be checked against the fixed ranking.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NT = 4;

    typedef enum logic [1:0] {
        TGT_WIN   = 2'd0,
        TGT_RAM   = 2'd1,
        TGT_CACHE = 2'd2,
        TGT_SDRAM = 2'd3
    } target_e;

    typedef enum logic [1:0] {
        OFF_WIN_REG,
        OFF_RAM_REG,
        OFF_MODULE,
        OFF_RESERVED
    } off_kind_e;

    typedef struct packed {
        logic [1:0] base;
        logic       en;
    } win_reg_t;

    typedef struct packed {
        logic [15:0] base;
        logic        en;
    } ram_reg_t;

    function automatic off_kind_e classify_offset(
        input logic [29:0] off,
        input logic [29:0] reg_blk_end,
        input logic [29:0] mod_end
    );
        if (off < reg_blk_end) begin
            if (off[29:2] == 28'd0)      return OFF_WIN_REG;
            else if (off[29:2] == 28'd2) return OFF_RAM_REG;
            else                         return OFF_RESERVED;
        end else if (off < mod_end) begin
            return OFF_MODULE;
        end
        return OFF_RESERVED;
    endfunction

    function automatic logic [DW-1:0] win_to_word(input win_reg_t r);
        return {r.base, 29'd0, r.en};
    endfunction

    function automatic logic [DW-1:0] ram_to_word(input ram_reg_t r);
        return {r.base, 15'd0, r.en};
    endfunction

endpackage

// File: rtl/pwd_regs.sv
module pwd_regs
    import pwd_pkg::*;
#(
    parameter logic [31:0] WIN_RST = 32'h4000_0001
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_win,
    input  logic            wr_ram,
    input  logic [DW-1:0]   wdata,
    output win_reg_t        win_q,
    output ram_reg_t        ram_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '{base: WIN_RST[31:30], en: WIN_RST[0]};
            ram_q <= '{base: 16'd0, en: 1'b0};
        end else begin
            if (wr_win) win_q <= '{base: wdata[31:30], en: wdata[0]};
            if (wr_ram) ram_q <= '{base: wdata[31:16], en: wdata[0]};
        end
    end

endmodule

// File: rtl/pwd_match.sv
module pwd_match
    import pwd_pkg::*;
#(
    parameter logic [31:0] CACHE_BASE  = 32'h0000_0000,
    parameter int          CACHE_LOG2  = 24
) (
    input  logic [AW-1:0] addr,
    input  win_reg_t      win_q,
    input  ram_reg_t      ram_q,
    output logic [NT-1:0] hits
);

    localparam int CTAG = AW - CACHE_LOG2;

    always_comb begin
        hits = '0;
        hits[TGT_WIN]   = win_q.en && (addr[31:30] == win_q.base);
        hits[TGT_RAM]   = ram_q.en && (addr[31:16] == ram_q.base);
        hits[TGT_CACHE] = (addr[AW-1 -: CTAG] == CACHE_BASE[AW-1 -: CTAG]);
        hits[TGT_SDRAM] = 1'b1;
    end

endmodule

// File: rtl/pwd_prio.sv
module pwd_prio
    import pwd_pkg::*;
(
    input  logic          valid,
    input  logic [NT-1:0] hits,
    output logic [NT-1:0] sel
);

    always_comb begin
        logic taken;
        sel   = '0;
        taken = 1'b0;
        for (int i = 0; i < NT; i++) begin
            if (valid && hits[i] && !taken) begin
                sel[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/periph_window_decoder.sv
module periph_window_decoder
    import pwd_pkg::*;
#(
    parameter logic [31:0] WIN_RST     = 32'h4000_0001,
    parameter logic [31:0] CACHE_BASE  = 32'h0000_0000,
    parameter int          CACHE_LOG2  = 24,
    parameter logic [29:0] REG_BLK_END = 30'h0000_0040,
    parameter logic [29:0] MOD_END     = 30'h0020_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [31:0]   req_addr,
    input  logic          req_write,
    input  logic [31:0]   req_wdata,
    output logic [3:0]    tgt_sel,
    output logic [31:0]   rd_data,
    output logic          err
);

    win_reg_t      win_q;
    ram_reg_t      ram_q;
    logic [NT-1:0] hits;
    off_kind_e     kind;
    logic          win_acc;
    logic          wr_win;
    logic          wr_ram;

    pwd_match #(
        .CACHE_BASE (CACHE_BASE),
        .CACHE_LOG2 (CACHE_LOG2)
    ) u_match (
        .addr  (req_addr),
        .win_q (win_q),
        .ram_q (ram_q),
        .hits  (hits)
    );

    pwd_prio u_prio (
        .valid (req_valid),
        .hits  (hits),
        .sel   (tgt_sel)
    );

    assign kind    = classify_offset(req_addr[29:0], REG_BLK_END, MOD_END);
    assign win_acc = tgt_sel[TGT_WIN];
    assign wr_win  = win_acc && req_write && (kind == OFF_WIN_REG);
    assign wr_ram  = win_acc && req_write && (kind == OFF_RAM_REG);

    pwd_regs #(
        .WIN_RST (WIN_RST)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_win (wr_win),
        .wr_ram (wr_ram),
        .wdata  (req_wdata),
        .win_q  (win_q),
        .ram_q  (ram_q)
    );

    always_comb begin
        rd_data = '0;
        if (win_acc && !req_write) begin
            case (kind)
                OFF_WIN_REG: rd_data = win_to_word(win_q);
                OFF_RAM_REG: rd_data = ram_to_word(ram_q);
                default:     rd_data = '0;
            endcase
        end
    end

    assign err = win_acc && (kind == OFF_RESERVED);

endmodule

// File: rtl/pwd_checker.sv
module pwd_checker
    import pwd_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_write,
    input logic [31:0]   req_wdata,
    input logic [3:0]    tgt_sel,
    input logic [31:0]   rd_data,
    input logic          err,
    input logic [NT-1:0] hits,
    input logic          wr_win,
    input win_reg_t      win_q,
    input ram_reg_t      ram_q
);

    p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($countones(tgt_sel) == 1));

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (tgt_sel == 4'b0000));

    p_win_first_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hits[TGT_WIN]) |-> tgt_sel[TGT_WIN]);

    p_err_in_win_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> (tgt_sel[TGT_WIN] && rd_data == 32'd0));

    p_win_off_r4: assert property (@(posedge clk) disable iff (rst)
        !win_q.en |-> !tgt_sel[TGT_WIN]);

    p_reset_val_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (win_q.en && win_q.base == 2'b01 && !ram_q.en));

    p_win_write_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_win)) |->
            (win_q.base == $past(req_wdata[31:30]) && win_q.en == $past(req_wdata[0])));

    p_win_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_win)) |-> $stable(win_q));

endmodule

bind periph_window_decoder pwd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .tgt_sel   (tgt_sel),
    .rd_data   (rd_data),
    .err       (err),
    .hits      (hits),
    .wr_win    (wr_win),
    .win_q     (win_q),
    .ram_q     (ram_q)
);

// File: tb/tb_periph_window_decoder.sv
module tb_periph_window_decoder;

    localparam logic [3:0] S_WIN = 4'b0001, S_RAM = 4'b0010,
                           S_CACHE = 4'b0100, S_SDRAM = 4'b1000, S_NONE = 4'b0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  tgt_sel;
    logic [31:0] rd_data;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0]  s_sel;
    logic [31:0] s_rd;
    logic        s_err;

    always #4 clk = ~clk;

    periph_window_decoder dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .tgt_sel   (tgt_sel),
        .rd_data   (rd_data),
        .err       (err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // Drive one request for one cycle; outputs sampled before the closing edge.
    task automatic acc(input logic [31:0] a, input logic w, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = w;
        req_wdata = d;
        #2;
        s_sel = tgt_sel;
        s_rd  = rd_data;
        s_err = err;
        @(posedge clk);
        #1 req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        acc(32'h4000_0000, 1'b0, '0);
        chk("R1", "base reg after reset", s_rd, 32'h4000_0001);
        chk("R2", "window select at reset base", {28'd0, s_sel}, {28'd0, S_WIN});
        chk("R11", "no err on base reg", {31'd0, s_err}, 32'd0);
        acc(32'h4000_0008, 1'b0, '0);
        chk("R1", "ram reg after reset", s_rd, 32'h0);
        acc(32'h4000_0008, 1'b1, 32'h1234_5678);
        chk("R11", "rd_data zero on write", s_rd, 32'h0);
    endtask

    task automatic t_idle_and_default();
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 32'h4000_0000;
        #2;
        chk("R8", "idle select", {28'd0, tgt_sel}, {28'd0, S_NONE});
        chk("R8", "idle err", {31'd0, err}, 32'd0);
        acc(32'h8000_0000, 1'b0, '0);
        chk("R7", "unclaimed goes to sdram", {28'd0, s_sel}, {28'd0, S_SDRAM});
        acc(32'h00FF_FFFC, 1'b0, '0);
        chk("R6", "cache top", {28'd0, s_sel}, {28'd0, S_CACHE});
        acc(32'h0100_0000, 1'b0, '0);
        chk("R6", "past cache", {28'd0, s_sel}, {28'd0, S_SDRAM});
    endtask

    task automatic t_reserved();
        do_reset();
        acc(32'h4000_0004, 1'b0, '0);
        chk("R9", "err at 0x04", {31'd0, s_err}, 32'd1);
        chk("R9", "rd zero at 0x04", s_rd, 32'h0);
        acc(32'h4020_0000, 1'b0, '0);
        chk("R9", "err above module space", {31'd0, s_err}, 32'd1);
        acc(32'h4000_003C, 1'b0, '0);
        chk("R9", "err at 0x3C", {31'd0, s_err}, 32'd1);
        acc(32'h401F_FFFC, 1'b0, '0);
        chk("R10", "module space end no err", {31'd0, s_err}, 32'd0);
        chk("R10", "module space selects window", {28'd0, s_sel}, {28'd0, S_WIN});
        acc(32'h4000_0040, 1'b0, '0);
        chk("R10", "module space start no err", {31'd0, s_err}, 32'd0);
        chk("R10", "module read zero", s_rd, 32'h0);
        acc(32'h4000_0004, 1'b1, 32'h0000_0000);
        chk("R9", "err on reserved write", {31'd0, s_err}, 32'd1);
        acc(32'h4000_000C, 1'b1, 32'hFFFF_0001);
        acc(32'h4000_0000, 1'b0, '0);
        chk("R9", "base reg untouched", s_rd, 32'h4000_0001);
        acc(32'h4000_0008, 1'b0, '0);
        chk("R9", "ram reg untouched", s_rd, 32'h0);
    endtask

    task automatic t_ram();
        do_reset();
        acc(32'h4000_0008, 1'b1, 32'h2000_FFFF);
        acc(32'h4000_0008, 1'b0, '0);
        chk("R5", "ram reg masked", s_rd, 32'h2000_0001);
        acc(32'h2000_FFFC, 1'b0, '0);
        chk("R5", "ram top", {28'd0, s_sel}, {28'd0, S_RAM});
        acc(32'h2001_0000, 1'b0, '0);
        chk("R5", "past ram", {28'd0, s_sel}, {28'd0, S_SDRAM});
        acc(32'h4000_0008, 1'b1, 32'h2000_0000);
        acc(32'h2000_0000, 1'b0, '0);
        chk("R5", "ram disabled", {28'd0, s_sel}, {28'd0, S_SDRAM});
    endtask

    task automatic t_relocate();
        do_reset();
        acc(32'h4000_0000, 1'b1, 32'hBFFF_FFFF);
        chk("R3", "write cycle uses old base", {28'd0, s_sel}, {28'd0, S_WIN});
        acc(32'h4000_0000, 1'b0, '0);
        chk("R3", "old base no longer decodes", {28'd0, s_sel}, {28'd0, S_SDRAM});
        acc(32'h8000_0000, 1'b0, '0);
        chk("R3", "new base decodes", {28'd0, s_sel}, {28'd0, S_WIN});
        chk("R3", "base reg masked", s_rd, 32'h8000_0001);
        acc(32'h8000_0000, 1'b1, 32'h8000_0000);
        chk("R4", "disabling write still decoded", {28'd0, s_sel}, {28'd0, S_WIN});
        acc(32'h8000_0000, 1'b0, '0);
        chk("R4", "window disabled", {28'd0, s_sel}, {28'd0, S_SDRAM});
        acc(32'h4000_0000, 1'b0, '0);
        chk("R4", "window disabled at reset base", {28'd0, s_sel}, {28'd0, S_SDRAM});
    endtask

    task automatic t_priority();
        do_reset();
        acc(32'h4000_0008, 1'b1, 32'h0000_0001);
        acc(32'h0000_1000, 1'b0, '0);
        chk("R7", "ram over cache", {28'd0, s_sel}, {28'd0, S_RAM});
        acc(32'h4000_0000, 1'b1, 32'h0000_0001);
        acc(32'h0000_1000, 1'b0, '0);
        chk("R7", "window over ram and cache", {28'd0, s_sel}, {28'd0, S_WIN});
        acc(32'h0000_0008, 1'b1, 32'h0000_0000);
        acc(32'h0000_0008, 1'b0, '0);
        chk("R7", "ram reg via moved window", s_rd, 32'h0);
        acc(32'h0000_1000, 1'b0, '0);
        chk("R7", "window still first", {28'd0, s_sel}, {28'd0, S_WIN});
        acc(32'h0000_0000, 1'b1, 32'h0000_0000);
        acc(32'h0000_1000, 1'b0, '0);
        chk("R7", "cache after window and ram off", {28'd0, s_sel}, {28'd0, S_CACHE});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_idle_and_default();
        t_reserved();
        t_ram();
        t_relocate();
        t_priority();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule